// File: doc/BRIEF.md
# Dual-Bitmap Overlay Code Generator

This block sits in a video output path and decides, pixel by pixel, whether one of two small programmable bitmaps covers the current position. Each bitmap is a grid of square blocks, and each block holds a 2-bit code: zero lets the underlying video through, while the three non-zero values name one of three overlay colors that a downstream mixer applies. The block only produces the code and a mesh-background flag. It does not touch pixel color.

The smaller bitmap is 16 by 16 blocks of 4x4 pixels. The larger one is 48 blocks wide and 16 high, with blocks of 8x8 pixels. Both read their codes from one 256-byte store that holds four codes per byte. Software fills the store through a byte-wide register port. It first selects the bitmap as the write target, then sets a byte index, then writes the byte. Each bitmap has its own horizontal origin and its own show/hide bit. Both share one vertical origin. An optional mesh background is flagged wherever a shown bitmap covers the pixel with a transparent code.

The pixel position arrives as column and line counters with an active strobe. Results leave two clock edges later, so they line up with a pixel stream that carries the same two-stage delay.

Top module: `osd_overlay_top`

## Requirements
- R1: While reset is high and after it is released, osd_code, osd_mesh and osd_mesh_gray are 0. Both bitmaps come out of reset hidden, and every configuration field is zero.
- R2: The outputs for the position presented at clock edge N appear after edge N+1 and hold until edge N+2.
- R3: The first bitmap covers columns H1*8 to H1*8+63 and lines V*16 to V*16+63. For the pixel at block (col = dx/4, row = dy/4), the code comes from store byte 192 + row*4 + col/4.
- R4: The second bitmap covers columns H2*8 to H2*8+383 and lines V*16 to V*16+127. For the pixel at block (col = dx/8, row = dy/8), the code comes from store byte row*12 + col/4.
- R5: Within a byte, the block with col mod 4 = 0 takes bits 7:6, mod 4 = 1 takes bits 5:4, mod 4 = 2 takes bits 3:2 and mod 4 = 3 takes bits 1:0.
- R6: osd_code is 00 when px_act is low, when the pixel lies outside both windows, or when the covering bitmap is hidden.
- R7: Where both shown windows cover a pixel, the first bitmap's code is output, even when that code is 00.
- R8: A write with cfg_sel = DATA stores cfg_wdata at the byte named by the index register, but only when the control write-select field is 2'b11. With any other write-select value the write changes nothing. The index holds its value until it is written again.
- R9: osd_mesh is 1 exactly when the mesh enable bit is set, px_act was high, a shown bitmap covers the pixel, and the code output is 00. osd_mesh_gray equals osd_mesh AND the mesh-color bit.
- R10: Register selects are CTRL=0, INDEX=1, DATA=2, H1=3, H2=4, VST=5. CTRL holds write-select in bits 1:0, the first bitmap's show bit in bit 3 and the second's in bit 4. H1 and H2 take their start from bits 7:3, in units of 8 columns. VST takes the vertical start from bits 7:4, in units of 16 lines, with mesh enable in bit 0 and mesh gray in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| px_x | input | 11 | Current pixel column |
| px_y | input | 10 | Current line |
| px_act | input | 1 | Active-picture strobe |
| osd_code | output | 2 | Overlay code, 00 means transparent |
| osd_mesh | output | 1 | Mesh background requested at this pixel |
| osd_mesh_gray | output | 1 | Mesh color is gray (valid with osd_mesh) |

## Verification
The hardest case to reach from the ports is the overlap region where a transparent code in the first bitmap has to hide a non-transparent code in the second. It only appears when both windows are shown, their origins intersect, and the store holds a suitable mix of zero and non-zero codes at the matching bytes. The stimulus loads every byte with a pattern that mixes these values, including whole zero bytes. It then places the two origins so that the smaller window falls inside the larger one and sweeps every column of sampled lines across both windows. A write with the wrong target select is aimed at a byte that the later sweep reads. Further configurations hide one bitmap, move the shared origin to its extreme value and toggle the active strobe mid-line.

// File: rtl/osd_pkg.sv
`timescale 1ns/1ps
package osd_pkg;
    localparam int X_W          = 11;
    localparam int Y_W          = 10;
    localparam int STORE_DEPTH  = 256;
    localparam int ADDR_W       = $clog2(STORE_DEPTH);
    localparam int H_UNIT_LOG2  = 3;
    localparam int V_UNIT_LOG2  = 4;
    localparam int HF_W         = 8 - H_UNIT_LOG2;
    localparam int VF_W         = 8 - V_UNIT_LOG2;
    localparam int NUM_BM       = 2;

    localparam int BM1_BLK_LOG2 = 2;
    localparam int BM1_COLS     = 16;
    localparam int BM1_ROWS     = 16;
    localparam int BM1_BASE     = 192;
    localparam int BM2_BLK_LOG2 = 3;
    localparam int BM2_COLS     = 48;
    localparam int BM2_ROWS     = 16;
    localparam int BM2_BASE     = 0;

    localparam logic [1:0] WSEL_BITMAP = 2'b11;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_INDEX = 3'd1,
        SEL_DATA  = 3'd2,
        SEL_H1    = 3'd3,
        SEL_H2    = 3'd4,
        SEL_VST   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [1:0]      wsel;
        logic            bm1_en;
        logic            bm2_en;
        logic [HF_W-1:0] h1;
        logic [HF_W-1:0] h2;
        logic [VF_W-1:0] v;
        logic            mesh_en;
        logic            mesh_gray;
    } osd_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        slot;
    } win_t;

    function automatic logic [1:0] pick_code(input logic [7:0] b, input logic [1:0] slot);
        case (slot)
            2'd0:    return b[7:6];
            2'd1:    return b[5:4];
            2'd2:    return b[3:2];
            default: return b[1:0];
        endcase
    endfunction
endpackage

// File: rtl/osd_regs.sv
`timescale 1ns/1ps
module osd_regs
    import osd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [7:0]        wdata,
    output osd_cfg_t          cfg,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata
);
    logic [ADDR_W-1:0] index_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            index_q <= '0;
        end else if (we) begin
            case (reg_sel_e'(sel))
                SEL_CTRL: begin
                    cfg.wsel   <= wdata[1:0];
                    cfg.bm1_en <= wdata[3];
                    cfg.bm2_en <= wdata[4];
                end
                SEL_INDEX: index_q <= wdata[ADDR_W-1:0];
                SEL_H1:    cfg.h1  <= wdata[7:H_UNIT_LOG2];
                SEL_H2:    cfg.h2  <= wdata[7:H_UNIT_LOG2];
                SEL_VST: begin
                    cfg.v         <= wdata[7:V_UNIT_LOG2];
                    cfg.mesh_gray <= wdata[1];
                    cfg.mesh_en   <= wdata[0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_we    = we && (reg_sel_e'(sel) == SEL_DATA) && (cfg.wsel == WSEL_BITMAP);
        mem_waddr = index_q;
        mem_wdata = wdata;
    end

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(we && reg_sel_e'(sel) == SEL_INDEX) |=> $stable(index_q)); // R8
endmodule

// File: rtl/osd_store.sv
`timescale 1ns/1ps
module osd_store #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/osd_window.sv
`timescale 1ns/1ps
module osd_window
    import osd_pkg::*;
#(
    parameter int BLK_LOG2 = 2,
    parameter int COLS     = 16,
    parameter int ROWS     = 16,
    parameter int BASE     = 192,
    parameter int XW       = X_W,
    parameter int YW       = Y_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW-1:0] hstart,
    input  logic [YW-1:0] vstart,
    input  logic          en,
    output win_t          w
);
    localparam int W_PIX = COLS << BLK_LOG2;
    localparam int H_PIX = ROWS << BLK_LOG2;
    localparam int BYTES = (COLS * ROWS) / 4;

    logic [XW-1:0] dx;
    logic [YW-1:0] dy;
    logic          in_x, in_y;
    logic [15:0]   col, row, idx;

    always_comb begin
        dx     = x - hstart;
        dy     = y - vstart;
        in_x   = (x >= hstart) && (dx < XW'(W_PIX));
        in_y   = (y >= vstart) && (dy < YW'(H_PIX));
        col    = 16'(dx >> BLK_LOG2);
        row    = 16'(dy >> BLK_LOG2);
        idx    = row * 16'(COLS) + col;
        w.hit  = en && in_x && in_y;
        w.addr = ADDR_W'(16'(BASE) + (idx >> 2));
        w.slot = idx[1:0];
    end

    AST_ADDR_IN_MAP: assert property (@(posedge clk) disable iff (rst)
        w.hit |-> ((int'(w.addr) >= BASE) && (int'(w.addr) < BASE + BYTES))); // R3, R4
endmodule

// File: rtl/osd_overlay_top.sv
`timescale 1ns/1ps
module osd_overlay_top
    import osd_pkg::*;
#(
    parameter int XW = X_W,
    parameter int YW = Y_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [7:0]    cfg_wdata,
    input  logic [XW-1:0] px_x,
    input  logic [YW-1:0] px_y,
    input  logic          px_act,
    output logic [1:0]    osd_code,
    output logic          osd_mesh,
    output logic          osd_mesh_gray
);
    osd_cfg_t          cfg;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [ADDR_W-1:0] raddr;
    logic [7:0]        rdata;
    logic [XW-1:0]     hst [NUM_BM];
    logic [YW-1:0]     vst;
    logic              shown [NUM_BM];
    win_t              win [NUM_BM];
    logic              take1, take2;
    logic [1:0]        slot_c;
    logic              s1_hit;
    logic [1:0]        s1_slot;
    logic [1:0]        code_c;

    osd_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .cfg(cfg), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    osd_store #(.DEPTH(STORE_DEPTH), .AW(ADDR_W)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(raddr), .rdata(rdata)
    );

    always_comb begin
        hst[0]   = XW'({cfg.h1, {H_UNIT_LOG2{1'b0}}});
        hst[1]   = XW'({cfg.h2, {H_UNIT_LOG2{1'b0}}});
        vst      = YW'({cfg.v, {V_UNIT_LOG2{1'b0}}});
        shown[0] = cfg.bm1_en;
        shown[1] = cfg.bm2_en;
    end

    for (genvar g = 0; g < NUM_BM; g++) begin : g_win
        localparam int BLK  = (g == 0) ? BM1_BLK_LOG2 : BM2_BLK_LOG2;
        localparam int COLS = (g == 0) ? BM1_COLS     : BM2_COLS;
        localparam int ROWS = (g == 0) ? BM1_ROWS     : BM2_ROWS;
        localparam int BASE = (g == 0) ? BM1_BASE     : BM2_BASE;
        osd_window #(
            .BLK_LOG2(BLK), .COLS(COLS), .ROWS(ROWS), .BASE(BASE), .XW(XW), .YW(YW)
        ) u_win (
            .clk(clk), .rst(rst), .x(px_x), .y(px_y),
            .hstart(hst[g]), .vstart(vst), .en(shown[g]), .w(win[g])
        );
    end

    // Stage 0: pick one bitmap per pixel; the first one wins on overlap.
    always_comb begin
        take1  = px_act && win[0].hit;
        take2  = px_act && win[1].hit && !take1;
        raddr  = take1 ? win[0].addr : win[1].addr;
        slot_c = take1 ? win[0].slot : win[1].slot;
    end

    // Stage 1: store read in flight, window result kept alongside.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_hit  <= 1'b0;
            s1_slot <= 2'd0;
        end else begin
            s1_hit  <= take1 || take2;
            s1_slot <= slot_c;
        end
    end

    always_comb code_c = s1_hit ? pick_code(rdata, s1_slot) : 2'b00;

    // Stage 2: registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            osd_code      <= 2'b00;
            osd_mesh      <= 1'b0;
            osd_mesh_gray <= 1'b0;
        end else begin
            osd_code      <= code_c;
            osd_mesh      <= cfg.mesh_en && s1_hit && (code_c == 2'b00);
            osd_mesh_gray <= cfg.mesh_en && cfg.mesh_gray && s1_hit && (code_c == 2'b00);
        end
    end

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !$past(px_act, 2) |-> (osd_code == 2'b00) && !osd_mesh); // R6
    AST_CODE_IN_WIN: assert property (@(posedge clk) disable iff (rst)
        (osd_code != 2'b00) |-> $past(s1_hit)); // R6
    AST_MESH_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
        osd_mesh |-> (osd_code == 2'b00)); // R9
    AST_GRAY_NEEDS_MESH: assert property (@(posedge clk) disable iff (rst)
        osd_mesh_gray |-> osd_mesh); // R9
endmodule

// File: tb/tb_osd_overlay_top.sv
`timescale 1ns/1ps
module tb_osd_overlay_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [10:0] px_x;
    logic [9:0]  px_y;
    logic        px_act;
    logic [1:0]  osd_code;
    logic        osd_mesh;
    logic        osd_mesh_gray;

    always #10 clk = ~clk;

    osd_overlay_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .px_x(px_x), .px_y(px_y), .px_act(px_act),
        .osd_code(osd_code), .osd_mesh(osd_mesh), .osd_mesh_gray(osd_mesh_gray)
    );

    typedef struct {
        int    tag;
        int    x;
        int    y;
        int    code;
        int    mesh;
        int    gray;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   done   = 0;

    // Shadow of the configuration, per R10.
    int shadow [256];
    int m_wsel = 0, m_bm1 = 0, m_bm2 = 0, m_h1 = 0, m_h2 = 0, m_v = 0;
    int m_mesh = 0, m_gray = 0, m_index = 0;

    always @(posedge clk) cyc = cyc + 1;

    // R10: register write; shadow follows the documented field layout.
    task automatic wr(input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 8'(data);
        case (sel)
            0: begin m_wsel = data & 3; m_bm1 = (data >> 3) & 1; m_bm2 = (data >> 4) & 1; end
            1: m_index = data & 255;
            2: if (m_wsel == 3) shadow[m_index] = data & 255; // R8
            3: m_h1 = (data >> 3) & 31;
            4: m_h2 = (data >> 3) & 31;
            5: begin m_v = (data >> 4) & 15; m_gray = (data >> 1) & 1; m_mesh = data & 1; end
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic exp_t model(input int x, input int y, input int act);
        exp_t e;
        int h1, h2, v, in1, in2, c, r, b, sh;
        h1 = m_h1 * 8; h2 = m_h2 * 8; v = m_v * 16;
        in1 = act && m_bm1 && x >= h1 && x < h1 + 64  && y >= v && y < v + 64;
        in2 = act && m_bm2 && x >= h2 && x < h2 + 384 && y >= v && y < v + 128;
        e.x = x; e.y = y; e.code = 0;
        if (in1) begin
            c = (x - h1) / 4; r = (y - v) / 4; b = 192 + r * 4 + c / 4;
            sh = 6 - 2 * (c % 4);
            e.code = (shadow[b] >> sh) & 3;
            e.req = in2 ? "R7 R3 R5" : "R3 R5";
        end else if (in2) begin
            c = (x - h2) / 8; r = (y - v) / 8; b = r * 12 + c / 4;
            sh = 6 - 2 * (c % 4);
            e.code = (shadow[b] >> sh) & 3;
            e.req = "R4 R5";
        end else begin
            e.req = "R6";
        end
        e.mesh = (m_mesh && (in1 || in2) && e.code == 0) ? 1 : 0;
        e.gray = e.mesh & m_gray;
        if (m_mesh != 0 && (in1 || in2)) e.req = {e.req, " R9"};
        return e;
    endfunction

    task automatic drive(input int x, input int y, input int act, input string req_override);
        exp_t e;
        @(negedge clk);
        px_x = 11'(x); px_y = 10'(y); px_act = act[0];
        e = model(x, y, act);
        if (req_override != "") e.req = req_override;
        e.tag = cyc;
        q.push_back(e);
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
        px_act = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: R2 two-edge latency; item driven before edge N is checked after edge N+1.
    always @(posedge clk) begin
        #5;
        while (q.size() > 0 && q[0].tag + 2 <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.tag + 2 != cyc || osd_code != 2'(e.code) || osd_mesh != e.mesh[0]
                || osd_mesh_gray != e.gray[0]) begin
                fails++;
                $display("FAIL %s R2: x=%0d y=%0d actual code=%0d mesh=%0d gray=%0d expected code=%0d mesh=%0d gray=%0d",
                         e.req, e.x, e.y, osd_code, osd_mesh, osd_mesh_gray, e.code, e.mesh, e.gray);
            end
        end
    end

    task automatic sweep(input int ymax, input int ystep, input int toggle);
        for (int y = 0; y <= ymax; y += ystep) begin
            drive(0, y, 0, "");
            for (int x = 0; x < 640; x++)
                drive(x, y, (toggle != 0 && x % 3 == 0) ? 0 : 1, "");
        end
        drain();
    endtask

    initial begin
        int t;
        t = 0;
        while (!done && t < 190000) begin @(posedge clk); t++; end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 3'd0; cfg_wdata = 8'd0;
        px_x = '0; px_y = '0; px_act = 1'b0;
        for (int i = 0; i < 256; i++) shadow[i] = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (osd_code != 2'b00 || osd_mesh || osd_mesh_gray) begin
            fails++;
            $display("FAIL R1: in reset actual code=%0d mesh=%0d gray=%0d expected 0 0 0",
                     osd_code, osd_mesh, osd_mesh_gray);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (osd_code != 2'b00 || osd_mesh || osd_mesh_gray) begin
            fails++;
            $display("FAIL R1: after reset actual code=%0d mesh=%0d expected 0 0", osd_code, osd_mesh);
        end
        // R1: bitmaps hidden after reset, so any active pixel gives code 0.
        for (int x = 0; x < 24; x++) drive(x * 9, x, 1, "R1");
        drain();

        // R8 R10: load the whole store with a mix of zero and non-zero codes.
        wr(0, 3);
        for (int i = 0; i < 256; i++) begin
            wr(1, i);
            wr(2, (i % 9 == 0) ? 0 : ((i * 73 + 29) & 255));
        end
        // R8: write with the wrong target select must be ignored.
        wr(0, 1);
        wr(1, 5);
        wr(2, ~((5 * 73 + 29)) & 255);

        // Config A: both shown, overlap, mesh gray.
        wr(0, 8'h19);            // wsel=01, bm1 on, bm2 on
        wr(3, 10 << 3);          // H1 = 80
        wr(4, 2 << 3);           // H2 = 16
        wr(5, (1 << 4) | 3);     // V = 16, mesh on, gray
        // R8: byte 5 covers bitmap-2 row 0, cols 20..23.
        for (int k = 0; k < 4; k++) drive(16 + (20 + k) * 8 + 3, 16, 1, "R8");
        drain();
        sweep(160, 7, 0);

        // Config B: first bitmap hidden, mesh off.
        wr(0, 8'h13);
        wr(4, 5 << 3);
        wr(5, 0);
        sweep(140, 5, 0);

        // Config C: first bitmap only at extreme origins, strobe toggling, mesh black.
        wr(0, 8'h0B);
        wr(3, 31 << 3);
        wr(5, (15 << 4) | 1);
        sweep(310, 7, 1);

        drain();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule